// File: doc/BRIEF.md
# Floating-point status and control register

This block is the status and control word of a single-precision floating-point unit. It holds four condition-code bits that a compare operation writes. It holds five mode bits: alternative half-precision, default NaN, flush-to-zero and a two-bit rounding mode. It also holds six cumulative exception flags. Software reads and writes the whole 32-bit word through a simple register port. The datapath raises exception flags with one-cycle set pulses and delivers compare results through a valid strobe.

A second register holds the startup mode bits. Software writes it through its own port. A load strobe copies its contents into the active mode field, for example when a new floating-point context begins. The exception flags accumulate until software clears them. Five of the flags are ORed into one interrupt request that has no per-flag mask. The inexact flag does not drive that request, so software must poll it.

Top module: `fpu_stat_ctrl`

## Requirements
- R1: After reset, `sw_rdata`, `dflt_rdata` and `irq` are all zero.
- R2: A software write takes effect on the next cycle. The word layout is:
  - condition bits N, Z, C, V at bits 31, 30, 29, 28;
  - alternative half-precision at bit 26, default NaN at bit 25, flush-to-zero at bit 24, rounding mode at bits 23:22;
  - denormal-input flag at bit 7, inexact at bit 4, underflow at bit 3, overflow at bit 2, divide-by-zero at bit 1, invalid at bit 0.

  All other bits read as zero and ignore writes, so writing all ones reads back 32'hF7C0_009F.
- R3: When `cmp_valid` is high, `cmp_nzcv` (bit 3 = N, down to bit 0 = V) is loaded into bits 31:28 on the next cycle. This takes priority over a software write in the same cycle.
- R4: Pulse `exc_set` bit k to set the flag for k on the next cycle. The mapping is 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 denormal input. A set flag stays set through later cycles and later operations until a software write clears it.
- R5: If a set pulse and a software write that clears the same flag arrive in the same cycle, the flag ends up set.
- R6: `irq` is high exactly when any of the flags at bits 7, 3, 2, 1 or 0 is set. The inexact flag (bit 4) alone never raises `irq`.
- R7: A write through `dflt_we` stores only bits 26:22 of `dflt_wdata`. `dflt_rdata` shows those bits in the same positions and zero elsewhere. Such a write leaves the active word unchanged.
- R8: When `load_dflt` is high, bits 26:22 of the active word take the default register's value on the next cycle. If a software write arrives in the same cycle, the load still wins for those bits, while the write still updates the condition bits and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe for the active word |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Active word read value |
| dflt_we | input | 1 | Write strobe for the default mode register |
| dflt_wdata | input | 32 | Default mode register write data |
| dflt_rdata | output | 32 | Default mode register read value |
| load_dflt | input | 1 | Copy default mode bits into the active word |
| cmp_valid | input | 1 | Compare result valid |
| cmp_nzcv | input | 4 | Compare result condition bits |
| exc_set | input | 6 | Per-flag set pulses from the datapath |
| irq | output | 1 | Combined exception interrupt request |

## Verification
A flag that fails to stick shows up on `sw_rdata` and possibly on `irq` one cycle after the pulse ends. A wrong interrupt mapping, such as the inexact flag being included, shows up on `irq` in the cycle after that flag is set. A priority error between a write and a pulse, compare or load is visible on the very next read of the active word. Comparing the full word against a reference model on every cycle therefore catches such faults within one clock of their cause.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned COND_W   = 4;
  localparam int unsigned COND_LSB = 28;
  localparam int unsigned MODE_W   = 5;
  localparam int unsigned MODE_LSB = 22;
  localparam int unsigned EXC_N    = 6;
  localparam int unsigned DNRM_IDX = 5;
  localparam int unsigned INEX_IDX = 4;
  localparam int unsigned DNRM_POS = 7;
  localparam logic [EXC_N-1:0] IRQ_SRC = ~(EXC_N'(1) << INEX_IDX);

  typedef struct packed {
    logic       alt_half;
    logic       dflt_nan;
    logic       flush_zero;
    logic [1:0] rnd;
  } mode_t;

  // word bit position of exception flag i
  function automatic int unsigned exc_pos(int unsigned i);
    return (i == DNRM_IDX) ? DNRM_POS : i;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(logic [COND_W-1:0] cond,
                                                  mode_t mode,
                                                  logic [EXC_N-1:0] exc);
    logic [WORD_W-1:0] w;
    w = '0;
    w[COND_LSB +: COND_W] = cond;
    w[MODE_LSB +: MODE_W] = mode;
    for (int unsigned i = 0; i < EXC_N; i++) w[exc_pos(i)] = exc[i];
    return w;
  endfunction

  function automatic logic [EXC_N-1:0] exc_of_word(logic [WORD_W-1:0] w);
    logic [EXC_N-1:0] e;
    for (int unsigned i = 0; i < EXC_N; i++) e[i] = w[exc_pos(i)];
    return e;
  endfunction

  function automatic logic irq_of(logic [EXC_N-1:0] exc);
    return |(exc & IRQ_SRC);
  endfunction
endpackage

// File: rtl/fsc_cond_reg.sv
module fsc_cond_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  logic [W-1:0] sw_val,
  input  logic         cmp_valid,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (cmp_valid) q <= cmp_val;
    else if (sw_we)     q <= sw_val;
  end
endmodule

// File: rtl/fsc_mode_reg.sv
module fsc_mode_reg
  import fsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dflt_we,
  input  mode_t dflt_val,
  input  logic  sw_we,
  input  mode_t sw_val,
  input  logic  load_dflt,
  output mode_t q,
  output mode_t dflt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      dflt_q <= '0;
    end else begin
      if (dflt_we) dflt_q <= dflt_val;
      if (load_dflt)  q <= dflt_q;
      else if (sw_we) q <= sw_val;
    end
  end
endmodule

// File: rtl/fsc_exc_reg.sv
module fsc_exc_reg #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  logic [N-1:0] sw_val,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (sw_we)  q[i] <= sw_val[i];
    end
  end
endmodule

// File: rtl/fpu_stat_ctrl.sv
module fpu_stat_ctrl
  import fsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_wdata,
  output logic [WORD_W-1:0] sw_rdata,
  input  logic              dflt_we,
  input  logic [WORD_W-1:0] dflt_wdata,
  output logic [WORD_W-1:0] dflt_rdata,
  input  logic              load_dflt,
  input  logic              cmp_valid,
  input  logic [COND_W-1:0] cmp_nzcv,
  input  logic [EXC_N-1:0]  exc_set,
  output logic              irq
);
  logic [COND_W-1:0] cond_q;
  mode_t             mode_q;
  mode_t             dflt_q;
  logic [EXC_N-1:0]  exc_q;
  logic [EXC_N-1:0]  sw_exc;

  assign sw_exc = exc_of_word(sw_wdata);

  fsc_cond_reg #(.W(COND_W)) u_cond (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we),
    .sw_val(sw_wdata[COND_LSB +: COND_W]),
    .cmp_valid(cmp_valid), .cmp_val(cmp_nzcv), .q(cond_q)
  );

  fsc_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n),
    .dflt_we(dflt_we), .dflt_val(mode_t'(dflt_wdata[MODE_LSB +: MODE_W])),
    .sw_we(sw_we), .sw_val(mode_t'(sw_wdata[MODE_LSB +: MODE_W])),
    .load_dflt(load_dflt), .q(mode_q), .dflt_q(dflt_q)
  );

  fsc_exc_reg #(.N(EXC_N)) u_exc (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_val(sw_exc),
    .set(exc_set), .q(exc_q)
  );

  assign sw_rdata   = pack_word(cond_q, mode_q, exc_q);
  assign dflt_rdata = pack_word('0, dflt_q, '0);
  assign irq        = irq_of(exc_q);
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
  import fsc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sw_we,
  input logic [WORD_W-1:0] sw_rdata,
  input logic [WORD_W-1:0] dflt_rdata,
  input logic              load_dflt,
  input logic              cmp_valid,
  input logic [COND_W-1:0] cmp_nzcv,
  input logic [EXC_N-1:0]  exc_set,
  input logic              irq
);
  localparam logic [WORD_W-1:0] LIVE = 32'hF7C0_009F;

  logic [EXC_N-1:0] flags;
  assign flags = {sw_rdata[7], sw_rdata[4:0]};

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata & ~LIVE) == '0);

  a_r3_cmp_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> sw_rdata[31:28] == $past(cmp_nzcv));

  a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_set) |=> (flags & $past(exc_set)) == $past(exc_set));

  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && exc_set == '0) |=> $stable(flags));

  a_r6_irq_sources: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (sw_rdata[7] | sw_rdata[3] | sw_rdata[2] | sw_rdata[1] | sw_rdata[0]));

  a_r8_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load_dflt |=> sw_rdata[26:22] == $past(dflt_rdata[26:22]));

  a_r7_mode_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !load_dflt) |=> $stable(sw_rdata[26:22]));
endmodule

bind fpu_stat_ctrl fsc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_rdata(sw_rdata),
  .dflt_rdata(dflt_rdata), .load_dflt(load_dflt), .cmp_valid(cmp_valid),
  .cmp_nzcv(cmp_nzcv), .exc_set(exc_set), .irq(irq)
);

// File: tb/fpu_stat_ctrl_bench.sv
module fpu_stat_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        dflt_we = 1'b0;
  logic [31:0] dflt_wdata = '0;
  logic [31:0] dflt_rdata;
  logic        load_dflt = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [3:0]  cmp_nzcv = '0;
  logic [5:0]  exc_set = '0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  logic [31:0] m_word = '0;
  logic [31:0] m_dflt = '0;
  bit done = 0;

  always #4 clk = ~clk;

  fpu_stat_ctrl u_fpu_stat_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .dflt_we(dflt_we), .dflt_wdata(dflt_wdata),
    .dflt_rdata(dflt_rdata), .load_dflt(load_dflt), .cmp_valid(cmp_valid),
    .cmp_nzcv(cmp_nzcv), .exc_set(exc_set), .irq(irq)
  );

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] flag_bit(int k);
    return (k == 5) ? 32'h80 : (32'h1 << k);
  endfunction

  // one clock: update model at the edge, compare at the falling edge
  task automatic step(string tag);
    logic [31:0] nxt;
    @(posedge clk);
    nxt = m_word;
    if (sw_we) nxt = (nxt & ~32'hF7C0_009F) | (sw_wdata & 32'hF7C0_009F);
    if (load_dflt) nxt = (nxt & ~32'h07C0_0000) | m_dflt;
    if (cmp_valid) nxt = {cmp_nzcv, nxt[27:0]};
    for (int k = 0; k < 6; k++) if (exc_set[k]) nxt = nxt | flag_bit(k);
    if (dflt_we) m_dflt = dflt_wdata & 32'h07C0_0000;
    m_word = nxt;
    @(negedge clk);
    chk32({tag, " word"}, sw_rdata, m_word);
    chk32({tag, " dflt"}, dflt_rdata, m_dflt);
    chk32({tag, " irq"}, {31'b0, irq}, {31'b0, (m_word & 32'h8F) != 0});
    sw_we = 0; dflt_we = 0; load_dflt = 0; cmp_valid = 0; exc_set = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk32("R1 word", sw_rdata, 32'h0);
    chk32("R1 dflt", dflt_rdata, 32'h0);
    chk32("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    step("R1 idle");

    sw_we = 1; sw_wdata = 32'hFFFF_FFFF; step("R2 all ones");
    chk32("R2 reserved", sw_rdata, 32'hF7C0_009F);
    sw_we = 1; sw_wdata = 32'h0; step("R2 clear");
    sw_we = 1; sw_wdata = 32'h5280_0000; step("R2 modes");

    cmp_valid = 1; cmp_nzcv = 4'b1010; step("R3 compare");
    chk32("R3 nzcv", {28'b0, sw_rdata[31:28]}, 32'hA);
    cmp_valid = 1; cmp_nzcv = 4'b0101; sw_we = 1; sw_wdata = 32'hF000_0000;
    step("R3 priority");
    chk32("R3 cmp wins", {28'b0, sw_rdata[31:28]}, 32'h5);

    sw_we = 1; sw_wdata = 32'h0; step("R4 clear");
    exc_set = 6'b010000; step("R6 inexact");
    chk32("R6 inexact no irq", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 3; i++) step("R4 hold");
    cmp_valid = 1; cmp_nzcv = 4'hF; step("R4 after op");
    chk32("R4 sticky", sw_rdata & 32'h10, 32'h10);

    for (int k = 0; k < 6; k++) begin
      if (k == 4) continue;
      sw_we = 1; sw_wdata = 32'h0; step("R4 clear each");
      exc_set = 6'(1 << k); step("R6 source");
      chk32("R6 irq on source", {31'b0, irq}, 32'h1);
      step("R4 held");
    end

    sw_we = 1; sw_wdata = 32'h0; exc_set = 6'b000100; step("R5 set wins");
    chk32("R5 overflow kept", sw_rdata & 32'h4, 32'h4);
    sw_we = 1; sw_wdata = 32'h0; step("R4 sw clears");
    chk32("R4 cleared", sw_rdata, 32'h0);

    dflt_we = 1; dflt_wdata = 32'hFFFF_FFFF; step("R7 default write");
    chk32("R7 active untouched", sw_rdata, 32'h0);
    load_dflt = 1; step("R8 load");
    chk32("R8 loaded", sw_rdata, 32'h07C0_0000);

    dflt_we = 1; dflt_wdata = 32'h0140_0000; step("R7 partial");
    sw_we = 1; sw_wdata = 32'hF6C0_0081; load_dflt = 1; step("R8 vs write");
    chk32("R8 load wins", sw_rdata, 32'hF140_0081);

    exc_set = 6'b100000; dflt_we = 1; dflt_wdata = 32'h0; step("R6 denorm");
    load_dflt = 1; step("R8 zero load");
    for (int i = 0; i < 20; i++) begin
      sw_we = i[0]; sw_wdata = 32'h9E5A_3C7B * (i + 1);
      exc_set = 6'(i * 7); cmp_valid = i[1]; cmp_nzcv = 4'(i);
      load_dflt = (i % 5 == 0); dflt_we = (i % 3 == 0); dflt_wdata = 32'h3A5C_F00F * i;
      step("R2 mixed");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule